// File: doc/BRIEF.md
# PHY Test-Port Access Sequencer

This block turns simple host register requests into the slow bit-level handshake of a PHY test port. The port has a test clock, a test enable, an 8-bit write bus toward the PHY, an 8-bit read bus back from it, and a test clear line. Every access opens with an address phase: enable is high, the address is on the write bus, and one generated clock pulse latches it. A write then runs a data phase with enable low, the data on the bus and a second clock pulse. A read drops enable, waits a programmable delay and samples the read bus.

Every port step lasts a programmable number of system cycles: the setup step, the clock-high step and the clock-low step. A step length of zero selects a built-in default. On demand the block also drives a clear pulse (low, then high, then low) on the test clear line. The host sees a busy flag for as long as a sequence runs. A read returns its byte with a one-cycle done strobe. A request whose address or write data does not fit in 8 bits is refused with a one-cycle reject strobe.

Top module: `tport_seq`

## Requirements
- R1: After a synchronous reset, busy, rd_done, req_reject, tst_clk, tst_en and tst_clr are low and tst_din is zero.
- R2: A write runs six steps: enable high with the address on tst_din, clock high, clock low, then enable low with the data on tst_din, clock high, clock low. It gives exactly two test clock pulses, and the PHY register at the address takes the data.
- R3: A read runs the three address-phase steps, then holds enable low for the read wait. It then samples tst_dout into rd_data and raises rd_done for exactly one cycle, in the cycle busy falls. It gives exactly one test clock pulse.
- R4: Every step lasts N system cycles, where N is step_len, or 4 when step_len is zero. Busy stays high for 6N cycles on a write, 3N+W cycles on a read and 3N cycles on a clear.
- R5: The read wait W equals rd_wait, and a value of zero is treated as one cycle.
- R6: A request is refused when any address bit above bit 7 is set, or, for a write, when any data bit above bit 7 is set. A refused request makes no port activity and leaves busy low, and req_reject pulses for one cycle in the following cycle.
- R7: Busy rises in the cycle after a request is accepted and falls when the last step ends. While busy is high, requests and clear requests are ignored, and the port stays quiet whenever busy is low.
- R8: A clear request holds tst_clr low for N cycles, then high for N cycles, then low for N cycles, with test clock and enable low throughout.
- R9: When a clear request and an access request arrive in the same idle cycle, the clear runs and the access is dropped.
- R10: tst_din stays constant for the whole time the test clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| step_len | input | CW | Cycles per port step; zero selects the default |
| rd_wait | input | CW | Cycles between the address phase and the read sample; zero means one |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | REQ_W | Register address; must fit in 8 bits |
| req_wdata | input | REQ_W | Write data; must fit in 8 bits |
| clr_req | input | 1 | Request a test-clear pulse |
| busy | output | 1 | Sequence in progress |
| rd_data | output | PW | Byte returned by the last read |
| rd_done | output | 1 | One-cycle strobe marking rd_data valid |
| req_reject | output | 1 | One-cycle strobe for a refused request |
| tst_clk | output | 1 | Generated test clock |
| tst_en | output | 1 | Test enable; high during the address phase |
| tst_din | output | PW | Address or data toward the PHY |
| tst_dout | input | PW | Read data from the PHY |
| tst_clr | output | 1 | Test clear line |

## Verification
The hardest case to reach is a request or clear arriving in the middle of a running sequence. The port must not change and the sequence length must stay the same. The stimulus injects a write and a clear request a few cycles into an operation. It then checks the busy length, the pulse counts and a later read-back of the injected address. Random operations mix step lengths and read waits, including both zero values, so every timing path is covered. Occasional addresses and data above 8 bits exercise rejection between valid accesses.

// File: rtl/tport_pkg.sv
package tport_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ASET, ST_ACKH, ST_ACKL,
    ST_DSET, ST_DCKH, ST_DCKL,
    ST_RWAIT,
    ST_CLO1, ST_CHI, ST_CLO2
  } tport_state_t;
endpackage

// File: rtl/tport_pacer.sv
module tport_pacer #(
  parameter int CW       = 8,
  parameter int DEF_STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          use_wait,
  input  logic [CW-1:0] step_len,
  input  logic [CW-1:0] wait_len,
  output logic          expired
);
  localparam logic [CW-1:0] DEF_V = CW'(DEF_STEP);
  localparam logic [CW-1:0] ONE_V = CW'(1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] eff_step, eff_wait, eff_len;

  always_comb begin
    eff_step = (step_len == '0) ? DEF_V : step_len;
    eff_wait = (wait_len == '0) ? ONE_V : wait_len;
    eff_len  = use_wait ? eff_wait : eff_step;
  end

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= eff_len - ONE_V;
    else if (cnt != '0) cnt <= cnt - ONE_V;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/tport_ctrl.sv
module tport_ctrl
  import tport_pkg::*;
#(
  parameter int PW    = 8,
  parameter int REQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [REQ_W-1:0] req_addr,
  input  logic [REQ_W-1:0] req_wdata,
  input  logic             clr_req,
  input  logic             expired,
  output logic             load,
  output logic             use_wait,
  output logic             busy,
  output logic [PW-1:0]    rd_data,
  output logic             rd_done,
  output logic             req_reject,
  output logic             tst_clk,
  output logic             tst_en,
  output logic [PW-1:0]    tst_din,
  input  logic [PW-1:0]    tst_dout,
  output logic             tst_clr
);
  localparam int HI_W = REQ_W - PW;

  tport_state_t state, nxt;
  logic          is_wr_q;
  logic [PW-1:0] wdata_q;
  logic          idle, bad, accept;

  assign idle   = (state == ST_IDLE);
  assign bad    = (req_addr[REQ_W-1 -: HI_W] != '0) ||
                  (req_write && (req_wdata[REQ_W-1 -: HI_W] != '0));
  assign accept = idle && !clr_req && req_valid && !bad;

  always_comb begin
    nxt = state;
    if (idle) begin
      if (clr_req)    nxt = ST_CLO1;
      else if (accept) nxt = ST_ASET;
    end else if (expired) begin
      case (state)
        ST_ASET:  nxt = ST_ACKH;
        ST_ACKH:  nxt = ST_ACKL;
        ST_ACKL:  nxt = is_wr_q ? ST_DSET : ST_RWAIT;
        ST_DSET:  nxt = ST_DCKH;
        ST_DCKH:  nxt = ST_DCKL;
        ST_CLO1:  nxt = ST_CHI;
        ST_CHI:   nxt = ST_CLO2;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  assign load     = (nxt != state) && (nxt != ST_IDLE);
  assign use_wait = (nxt == ST_RWAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      is_wr_q    <= 1'b0;
      wdata_q    <= '0;
      busy       <= 1'b0;
      rd_data    <= '0;
      rd_done    <= 1'b0;
      req_reject <= 1'b0;
      tst_clk    <= 1'b0;
      tst_en     <= 1'b0;
      tst_din    <= '0;
      tst_clr    <= 1'b0;
    end else begin
      state      <= nxt;
      busy       <= (nxt != ST_IDLE);
      tst_clk    <= (nxt == ST_ACKH) || (nxt == ST_DCKH);
      tst_en     <= (nxt == ST_ASET) || (nxt == ST_ACKH) || (nxt == ST_ACKL);
      tst_clr    <= (nxt == ST_CHI);
      req_reject <= idle && !clr_req && req_valid && bad;
      rd_done    <= 1'b0;
      if (accept) begin
        is_wr_q <= req_write;
        wdata_q <= req_wdata[PW-1:0];
        tst_din <= req_addr[PW-1:0];
      end
      if (nxt == ST_DSET && state != ST_DSET) tst_din <= wdata_q;
      if (state == ST_RWAIT && expired) begin
        rd_data <= tst_dout;
        rd_done <= 1'b1;
      end
    end
  end

  // R8
  port_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tst_clk && tst_clr));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!tst_clk && !tst_en && !tst_clr));
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done);
  // R6
  reject_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_reject |-> !busy);
  // R10
  din_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tst_clk |-> $stable(tst_din));
  // R2
  en_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tst_en) |-> !tst_clk);
endmodule

// File: rtl/tport_seq.sv
module tport_seq #(
  parameter int PW       = 8,
  parameter int REQ_W    = 16,
  parameter int CW       = 8,
  parameter int DEF_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    step_len,
  input  logic [CW-1:0]    rd_wait,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [REQ_W-1:0] req_addr,
  input  logic [REQ_W-1:0] req_wdata,
  input  logic             clr_req,
  output logic             busy,
  output logic [PW-1:0]    rd_data,
  output logic             rd_done,
  output logic             req_reject,
  output logic             tst_clk,
  output logic             tst_en,
  output logic [PW-1:0]    tst_din,
  input  logic [PW-1:0]    tst_dout,
  output logic             tst_clr
);
  logic load, use_wait, expired;

  tport_pacer #(.CW(CW), .DEF_STEP(DEF_STEP)) u_pacer (
    .clk(clk), .rst(rst), .load(load), .use_wait(use_wait),
    .step_len(step_len), .wait_len(rd_wait), .expired(expired)
  );

  tport_ctrl #(.PW(PW), .REQ_W(REQ_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .clr_req(clr_req),
    .expired(expired), .load(load), .use_wait(use_wait),
    .busy(busy), .rd_data(rd_data), .rd_done(rd_done),
    .req_reject(req_reject), .tst_clk(tst_clk), .tst_en(tst_en),
    .tst_din(tst_din), .tst_dout(tst_dout), .tst_clr(tst_clr)
  );
endmodule

// File: tb/tport_seq_test.sv
`timescale 1ns/1ps
module tport_seq_test;
  logic clk = 0;
  logic rst = 1;
  logic [7:0]  step_len = 0, rd_wait = 0;
  logic        req_valid = 0, req_write = 0, clr_req = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic        busy, rd_done, req_reject, tst_clk, tst_en, tst_clr;
  logic [7:0]  rd_data, tst_din, tst_dout;

  always #4 clk = ~clk;

  tport_seq uut (
    .clk(clk), .rst(rst), .step_len(step_len), .rd_wait(rd_wait),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .clr_req(clr_req), .busy(busy),
    .rd_data(rd_data), .rd_done(rd_done), .req_reject(req_reject),
    .tst_clk(tst_clk), .tst_en(tst_en), .tst_din(tst_din),
    .tst_dout(tst_dout), .tst_clr(tst_clr)
  );

  // PHY register file model
  logic [7:0] phy_mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] lat_addr = 0;
  always @(posedge tst_clk) begin
    if (tst_en) lat_addr <= tst_din;
    else        phy_mem[lat_addr] <= tst_din;
  end
  assign tst_dout = phy_mem[lat_addr];

  int checks = 0, errors = 0;
  int busy_cyc, clk_rise, clr_rise, clr_hi, en_hi, din_bad, done_cnt, rej_cnt;
  logic [7:0] cap_data;
  logic p_clk = 0, p_clr = 0;
  logic [7:0] p_din = 0;

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (tst_clk && !p_clk) clk_rise++;
    if (tst_clr && !p_clr) clr_rise++;
    if (tst_clr) clr_hi++;
    if (tst_en) en_hi++;
    if (tst_clk && p_clk && tst_din != p_din) din_bad++;
    if (rd_done) begin done_cnt++; cap_data = rd_data; end
    if (req_reject) rej_cnt++;
    p_clk = tst_clk; p_clr = tst_clr; p_din = tst_din;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff_n(input int n); return (n == 0) ? 4 : n; endfunction
  function automatic int eff_w(input int w); return (w == 0) ? 1 : w; endfunction

  // kind: 0 write, 1 read, 2 clear, 3 clear+write together
  task automatic run_op(input int kind, input int a, input int d, input bit inject);
    @(posedge clk); #1;
    busy_cyc = 0; clk_rise = 0; clr_rise = 0; clr_hi = 0; en_hi = 0;
    din_bad = 0; done_cnt = 0; rej_cnt = 0;
    req_addr = 16'(a); req_wdata = 16'(d);
    req_write = (kind != 1);
    req_valid = (kind != 2);
    clr_req = (kind >= 2);
    @(posedge clk); #1;
    req_valid = 0; clr_req = 0;
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      if (inject && i == 3) begin
        req_valid = 1; req_write = 1; req_addr = 16'hAA; req_wdata = 16'h33; clr_req = 1;
      end else begin
        req_valid = 0; clr_req = 0;
      end
      @(posedge clk); #1;
    end
    req_valid = 0; clr_req = 0;
    @(negedge clk); #1;
  endtask

  task automatic do_check(input int kind, input int a, input int d);
    int n, w;
    bit bad;
    n = eff_n(step_len); w = eff_w(rd_wait);
    bad = (kind < 2) && ((a > 255) || (kind == 0 && d > 255));
    if (bad) begin
      check(rej_cnt == 1, "R6 reject pulse", rej_cnt, 1);
      check(busy_cyc == 0 && clk_rise == 0, "R6 no activity", busy_cyc + clk_rise, 0);
    end else if (kind == 0) begin
      check(busy_cyc == 6*n, "R4 write length", busy_cyc, 6*n);
      check(clk_rise == 2, "R2 write pulses", clk_rise, 2);
      check(en_hi == 3*n, "R2 enable span", en_hi, 3*n);
      check(din_bad == 0, "R10 din hold", din_bad, 0);
      exp_mem[a] = 8'(d);
    end else if (kind == 1) begin
      check(busy_cyc == 3*n + w, "R4 R5 read length", busy_cyc, 3*n + w);
      check(clk_rise == 1, "R3 read pulses", clk_rise, 1);
      check(done_cnt == 1, "R3 done pulse", done_cnt, 1);
      check(cap_data == exp_mem[a], "R3 read data", cap_data, exp_mem[a]);
    end else begin
      check(busy_cyc == 3*n, "R8 clear length", busy_cyc, 3*n);
      check(clr_rise == 1 && clr_hi == n, "R8 clear high span", clr_hi, n);
      check(clk_rise == 0 && en_hi == 0, "R8 R9 port quiet", clk_rise + en_hi, 0);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed, k, a, d;
    seed = $urandom(32'h1234);
    for (int i = 0; i < 256; i++) begin
      phy_mem[i] = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(!busy && !rd_done && !req_reject, "R1 host outputs", busy, 0);
    check(!tst_clk && !tst_en && !tst_clr && tst_din == 0, "R1 port outputs", tst_din, 0);
    rst = 0;

    // directed: defaults (zero step and zero wait)
    step_len = 0; rd_wait = 0;
    run_op(0, 8'h12, 8'hC3, 0); do_check(0, 8'h12, 8'hC3);
    run_op(1, 8'h12, 0, 0);     do_check(1, 8'h12, 0);
    run_op(2, 0, 0, 0);         do_check(2, 0, 0);
    // boundary addresses and rejections
    step_len = 1; rd_wait = 3;
    run_op(0, 255, 255, 0);     do_check(0, 255, 255);
    run_op(1, 255, 0, 0);       do_check(1, 255, 0);
    run_op(0, 256, 1, 0);       do_check(0, 256, 1);
    run_op(0, 5, 16'h100, 0);   do_check(0, 5, 16'h100);
    run_op(1, 16'h8001, 0, 0);  do_check(1, 16'h8001, 0);
    run_op(1, 5, 0, 0);         do_check(1, 5, 0);
    // R9 clear wins over a same-cycle write
    step_len = 2;
    run_op(3, 8'h40, 8'h99, 0); do_check(3, 8'h40, 8'h99);
    run_op(1, 8'h40, 0, 0);     do_check(1, 8'h40, 0);
    // R7 requests during busy are ignored
    step_len = 3;
    run_op(0, 8'h21, 8'h7E, 1); do_check(0, 8'h21, 8'h7E);
    check(busy == 0, "R7 no late start", busy, 0);
    run_op(1, 8'hAA, 0, 0);     do_check(1, 8'hAA, 0);
    run_op(2, 0, 0, 1);         do_check(2, 0, 0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      step_len = 8'($urandom % 6);
      rd_wait  = 8'($urandom % 7);
      k = $urandom % 3;
      a = (($urandom % 8) == 0) ? 256 + ($urandom % 100) : ($urandom % 256);
      d = (($urandom % 10) == 0) ? 300 : ($urandom % 256);
      run_op(k, a, d, 0);
      do_check(k, a, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule